// File: doc/BRIEF.md
# Status-Flag Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a small accumulator-style processor datapath. Each evaluation takes two operands, a 5-bit operation code and the present carry and zero flags, and returns a result, a write-enable for that result, a vector of six new flag values and a mask of the flags that the operation updates. A sequencer outside the block merges the masked flags into its status register and writes the result back when the enable is high.

The operations are addition and subtraction with and without incoming carry, compares with and without carry that write nothing, bitwise AND, OR and XOR, one's and two's complement, increment, decrement, logical shifts, an arithmetic right shift, rotates through carry and a half-swap. Each operation touches its own fixed subset of flags. The half-carry flag is produced at the midpoint of the operand width. The sign-test flag is the exclusive OR of negative and overflow. The carry-chained subtract and compare can only clear zero, so a compare across several bytes leaves zero set only when every byte matched.

The datapath width is a parameter (even, at least 4). A second parameter selects between a bit-level ripple carry chain built with a generate loop and a set of wide adders. Both variants give identical outputs.

Top module: `flag_alu`

## Requirements
- R1: Code 0 returns A+B and code 1 returns A+B+carry_i; both update all six flags, with C the carry out of the top bit and H the carry out of bit WIDTH/2-1.
- R2: Code 2 returns A-B and code 3 returns A-B-carry_i; both update all six flags, with C set on a borrow out of the top bit and H set on a borrow into bit WIDTH/2.
- R3: Code 4 (compare) and code 5 (compare with carry) produce the flags of codes 2 and 3 with wr_en_o low.
- R4: For codes 3 and 5 the new Z is 1 only when the result is zero and zero_i is 1.
- R5: Codes 6, 7 and 8 return A AND B, A OR B and A XOR B, and update only Z, N, V and S, with V forced to 0.
- R6: Code 9 returns the bitwise inverse of A with C=1 and V=0 and updates Z, C, N, V and S. Code 10 returns 0-A, updates all six flags, sets C when the result is nonzero, sets V when the result is the most negative value, and sets H when the low half of A is nonzero.
- R7: Code 11 returns A+1 and code 12 returns A-1. Both update only Z, N, V and S. V is set for code 11 when A is the largest positive value, and for code 12 when A is the most negative value.
- R8: The five shift codes update Z, C, N, V and S, with C the bit shifted out and V = N xor C. Code 13 shifts left with 0 entering. Code 14 shifts right with 0 entering. Code 15 shifts right keeping the top bit. Code 16 rotates left with carry_i entering bit 0. Code 17 rotates right with carry_i entering the top bit.
- R9: Code 18 exchanges the upper and lower halves of A and updates no flag.
- R10: Whenever S is in the mask, the new S equals the new N xor the new V.
- R11: Flag bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. A flag outside the mask is output as carry_i in position 0, as zero_i in position 1, and as 0 in every other position.
- R12: Codes 19 to 31 give result 0, wr_en_o low and an empty mask.
- R13: wr_en_o is high for codes 0 to 3 and 6 to 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Present carry flag |
| zero_i | input | 1 | Present zero flag |
| result_o | output | WIDTH | Operation result |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 6 | New flag values (C, Z, N, V, S, H from bit 0 up) |
| upd_o | output | 6 | Mask of flags updated by the operation |

## Verification
The bound checker evaluates several properties on every input change. It requires that S agrees with N and V, that unmasked carry and zero pass through, that compares never write and invalid codes do nothing, and that logical operations never report overflow. It also checks that a carry-chained subtract cannot raise zero, that the half-swap leaves the flags alone, and that plain addition matches the operand sum and carry. The exact per-operation values are shown only by the bench's sweep against its arithmetic model. These cover half carry, borrow and overflow at the signed boundaries, the rotate inputs and the masks of each code. A directed two-byte compare shows zero chaining across bytes.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   localparam int NUM_FLAGS = 6;
   localparam int OP_BITS   = 5;

   // flag vector bit positions
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_N = 2;
   localparam int FL_V = 3;
   localparam int FL_S = 4;
   localparam int FL_H = 5;

   typedef logic [NUM_FLAGS-1:0] flag_vec_t;

   localparam flag_vec_t MASK_ALL   = 6'b111111;
   localparam flag_vec_t MASK_ZCNVS = 6'b011111;
   localparam flag_vec_t MASK_ZNVS  = 6'b011110;
   localparam flag_vec_t MASK_NONE  = 6'b000000;

   typedef enum logic [OP_BITS-1:0] {
      OP_ADD  = 5'd0,
      OP_ADDC = 5'd1,
      OP_SUB  = 5'd2,
      OP_SUBC = 5'd3,
      OP_CMP  = 5'd4,
      OP_CMPC = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_INV  = 5'd9,
      OP_NEG  = 5'd10,
      OP_INC  = 5'd11,
      OP_DEC  = 5'd12,
      OP_SHL  = 5'd13,
      OP_SHR  = 5'd14,
      OP_SAR  = 5'd15,
      OP_RCL  = 5'd16,
      OP_RCR  = 5'd17,
      OP_XCHG = 5'd18
   } alu_op_e;

   typedef enum logic [1:0] {
      BW_AND,
      BW_OR,
      BW_XOR,
      BW_INV
   } bw_mode_e;

   typedef enum logic [2:0] {
      SH_LEFT,
      SH_RIGHT,
      SH_RIGHT_ARITH,
      SH_ROT_LEFT,
      SH_ROT_RIGHT,
      SH_HALF_XCHG
   } sh_mode_e;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_ARITH,
      SRC_BITWISE,
      SRC_SHIFT
   } res_src_e;

   typedef enum logic [1:0] {
      CY_ARITH,
      CY_SHIFT,
      CY_ONE
   } cy_src_e;

   typedef enum logic [1:0] {
      OV_ARITH,
      OV_ZERO,
      OV_SHIFT
   } ov_src_e;

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             half_o,
   output logic             ovf_o
);

   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] b_eff;
   logic             c_first;
   logic             raw_top;
   logic             raw_half;
   logic             into_msb;

   // subtraction is A + ~B + ~borrow; carries come out inverted as borrows
   assign b_eff   = sub_i ? ~b_i : b_i;
   assign c_first = cin_i ^ sub_i;

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = c_first;
      for (genvar g = 0; g < WIDTH; g++) begin : g_bit
         assign sum_o[g]  = a_i[g] ^ b_eff[g] ^ cy[g];
         assign cy[g+1]   = (a_i[g] & b_eff[g]) | (cy[g] & (a_i[g] ^ b_eff[g]));
      end
      assign raw_top  = cy[WIDTH];
      assign raw_half = cy[HALF];
      assign into_msb = cy[WIDTH-1];
   end else begin : g_wide
      logic [WIDTH:0]   full_sum;
      logic [HALF:0]    low_sum;
      logic [WIDTH-1:0] part_sum;
      assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_first};
      assign low_sum  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]}
                      + {{HALF{1'b0}}, c_first};
      assign part_sum = {1'b0, a_i[WIDTH-2:0]} + {1'b0, b_eff[WIDTH-2:0]}
                      + {{(WIDTH-1){1'b0}}, c_first};
      assign sum_o    = full_sum[WIDTH-1:0];
      assign raw_top  = full_sum[WIDTH];
      assign raw_half = low_sum[HALF];
      assign into_msb = part_sum[WIDTH-1];
   end

   assign cout_o = raw_top ^ sub_i;
   assign half_o = raw_half ^ sub_i;
   assign ovf_o  = raw_top ^ into_msb;

endmodule

// File: rtl/flag_alu_bitwise.sv
module flag_alu_bitwise
   import flag_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  bw_mode_e         mode_i,
   output logic [WIDTH-1:0] y_o
);

   always_comb begin
      unique case (mode_i)
         BW_AND:  y_o = a_i & b_i;
         BW_OR:   y_o = a_i | b_i;
         BW_XOR:  y_o = a_i ^ b_i;
         default: y_o = ~a_i;
      endcase
   end

endmodule

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter
   import flag_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             cin_i,
   input  sh_mode_e         mode_i,
   output logic [WIDTH-1:0] y_o,
   output logic             cout_o
);

   localparam int HALF = WIDTH / 2;

   always_comb begin
      y_o    = a_i;
      cout_o = 1'b0;
      case (mode_i)
         SH_LEFT: begin
            y_o    = {a_i[WIDTH-2:0], 1'b0};
            cout_o = a_i[WIDTH-1];
         end
         SH_RIGHT: begin
            y_o    = {1'b0, a_i[WIDTH-1:1]};
            cout_o = a_i[0];
         end
         SH_RIGHT_ARITH: begin
            y_o    = {a_i[WIDTH-1], a_i[WIDTH-1:1]};
            cout_o = a_i[0];
         end
         SH_ROT_LEFT: begin
            y_o    = {a_i[WIDTH-2:0], cin_i};
            cout_o = a_i[WIDTH-1];
         end
         SH_ROT_RIGHT: begin
            y_o    = {cin_i, a_i[WIDTH-1:1]};
            cout_o = a_i[0];
         end
         SH_HALF_XCHG: begin
            y_o    = {a_i[HALF-1:0], a_i[WIDTH-1:HALF]};
            cout_o = 1'b0;
         end
         default: begin
            y_o    = a_i;
            cout_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [OP_BITS-1:0]   op_i,
   input  logic [WIDTH-1:0]     a_i,
   input  logic [WIDTH-1:0]     b_i,
   input  logic                 carry_i,
   input  logic                 zero_i,
   output logic [WIDTH-1:0]     result_o,
   output logic                 wr_en_o,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic [NUM_FLAGS-1:0] upd_o
);

   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("flag_alu: WIDTH must be even and at least 4");
   end

   // operation decode
   logic [WIDTH-1:0] ar_a, ar_b;
   logic             ar_sub, ar_cin;
   bw_mode_e         bw_mode;
   sh_mode_e         sh_mode;
   res_src_e         res_src;
   cy_src_e          cy_src;
   ov_src_e          ov_src;
   logic             z_chain;
   logic             we;
   flag_vec_t        mask;

   always_comb begin
      ar_a    = a_i;
      ar_b    = b_i;
      ar_sub  = 1'b0;
      ar_cin  = 1'b0;
      bw_mode = BW_AND;
      sh_mode = SH_LEFT;
      res_src = SRC_NONE;
      cy_src  = CY_ARITH;
      ov_src  = OV_ARITH;
      z_chain = 1'b0;
      we      = 1'b1;
      mask    = MASK_NONE;
      case (op_i)
         OP_ADD: begin
            res_src = SRC_ARITH;
            mask    = MASK_ALL;
         end
         OP_ADDC: begin
            res_src = SRC_ARITH;
            ar_cin  = carry_i;
            mask    = MASK_ALL;
         end
         OP_SUB, OP_CMP: begin
            res_src = SRC_ARITH;
            ar_sub  = 1'b1;
            mask    = MASK_ALL;
            we      = (op_i == OP_SUB);
         end
         OP_SUBC, OP_CMPC: begin
            res_src = SRC_ARITH;
            ar_sub  = 1'b1;
            ar_cin  = carry_i;
            z_chain = 1'b1;
            mask    = MASK_ALL;
            we      = (op_i == OP_SUBC);
         end
         OP_AND, OP_OR, OP_XOR: begin
            res_src = SRC_BITWISE;
            ov_src  = OV_ZERO;
            mask    = MASK_ZNVS;
            bw_mode = (op_i == OP_AND) ? BW_AND :
                      (op_i == OP_OR)  ? BW_OR  : BW_XOR;
         end
         OP_INV: begin
            res_src = SRC_BITWISE;
            bw_mode = BW_INV;
            cy_src  = CY_ONE;
            ov_src  = OV_ZERO;
            mask    = MASK_ZCNVS;
         end
         OP_NEG: begin
            res_src = SRC_ARITH;
            ar_a    = '0;
            ar_b    = a_i;
            ar_sub  = 1'b1;
            mask    = MASK_ALL;
         end
         OP_INC, OP_DEC: begin
            res_src = SRC_ARITH;
            ar_b    = '0;
            ar_cin  = 1'b1;
            ar_sub  = (op_i == OP_DEC);
            mask    = MASK_ZNVS;
         end
         OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR: begin
            res_src = SRC_SHIFT;
            cy_src  = CY_SHIFT;
            ov_src  = OV_SHIFT;
            mask    = MASK_ZCNVS;
            case (op_i)
               OP_SHL:  sh_mode = SH_LEFT;
               OP_SHR:  sh_mode = SH_RIGHT;
               OP_SAR:  sh_mode = SH_RIGHT_ARITH;
               OP_RCL:  sh_mode = SH_ROT_LEFT;
               default: sh_mode = SH_ROT_RIGHT;
            endcase
         end
         OP_XCHG: begin
            res_src = SRC_SHIFT;
            sh_mode = SH_HALF_XCHG;
            mask    = MASK_NONE;
         end
         default: begin
            we   = 1'b0;
            mask = MASK_NONE;
         end
      endcase
   end

   // datapath units
   logic [WIDTH-1:0] ar_sum, bw_y, sh_y;
   logic             ar_cout, ar_half, ar_ovf, sh_cout;

   flag_alu_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .a_i    (ar_a),
      .b_i    (ar_b),
      .sub_i  (ar_sub),
      .cin_i  (ar_cin),
      .sum_o  (ar_sum),
      .cout_o (ar_cout),
      .half_o (ar_half),
      .ovf_o  (ar_ovf)
   );

   flag_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a_i    (a_i),
      .b_i    (b_i),
      .mode_i (bw_mode),
      .y_o    (bw_y)
   );

   flag_alu_shifter #(.WIDTH(WIDTH)) u_shifter (
      .a_i    (a_i),
      .cin_i  (carry_i),
      .mode_i (sh_mode),
      .y_o    (sh_y),
      .cout_o (sh_cout)
   );

   // result select and flag formation
   logic [WIDTH-1:0] res;
   logic             f_c, f_z, f_n, f_v;
   flag_vec_t        computed;

   always_comb begin
      unique case (res_src)
         SRC_ARITH:   res = ar_sum;
         SRC_BITWISE: res = bw_y;
         SRC_SHIFT:   res = sh_y;
         default:     res = '0;
      endcase
   end

   always_comb begin
      f_n = res[WIDTH-1];
      f_z = (res == '0) & (~z_chain | zero_i);
      unique case (cy_src)
         CY_SHIFT: f_c = sh_cout;
         CY_ONE:   f_c = 1'b1;
         default:  f_c = ar_cout;
      endcase
      unique case (ov_src)
         OV_ZERO:  f_v = 1'b0;
         OV_SHIFT: f_v = f_n ^ f_c;
         default:  f_v = ar_ovf;
      endcase
   end

   always_comb begin
      computed       = '0;
      computed[FL_C] = f_c;
      computed[FL_Z] = f_z;
      computed[FL_N] = f_n;
      computed[FL_V] = f_v;
      computed[FL_S] = f_n ^ f_v;
      computed[FL_H] = ar_half;
   end

   // untouched flags: carry and zero pass through, the rest read as zero
   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      if (f == FL_C) begin : g_keep_c
         assign flags_o[f] = mask[f] ? computed[f] : carry_i;
      end else if (f == FL_Z) begin : g_keep_z
         assign flags_o[f] = mask[f] ? computed[f] : zero_i;
      end else begin : g_plain
         assign flags_o[f] = mask[f] & computed[f];
      end
   end

   assign result_o = res;
   assign wr_en_o  = we;
   assign upd_o    = mask;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
   import flag_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic [OP_BITS-1:0]   op_i,
   input logic [WIDTH-1:0]     a_i,
   input logic [WIDTH-1:0]     b_i,
   input logic                 carry_i,
   input logic                 zero_i,
   input logic [WIDTH-1:0]     result_o,
   input logic                 wr_en_o,
   input logic [NUM_FLAGS-1:0] flags_o,
   input logic [NUM_FLAGS-1:0] upd_o
);

   localparam int HALF = WIDTH / 2;

   logic [WIDTH:0] plain_sum;
   assign plain_sum = {1'b0, a_i} + {1'b0, b_i};

   always_comb begin
      // R1
      add_sum_chk: assert (op_i != OP_ADD ||
                           (result_o == plain_sum[WIDTH-1:0] && flags_o[FL_C] == plain_sum[WIDTH]))
         else $error("plain addition disagrees with operand sum");
      // R3
      cmp_no_write_chk: assert (!(op_i == OP_CMP || op_i == OP_CMPC) || !wr_en_o)
         else $error("compare requested a write");
      // R4
      zero_chain_chk: assert (!(op_i == OP_SUBC || op_i == OP_CMPC) || zero_i || !flags_o[FL_Z])
         else $error("chained subtract raised zero");
      // R5
      logic_no_ovf_chk: assert (!(op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) ||
                                (!flags_o[FL_V] && !upd_o[FL_C] && !upd_o[FL_H]))
         else $error("logical operation touched carry, half or overflow");
      // R9
      xchg_chk: assert (op_i != OP_XCHG ||
                        (upd_o == '0 && result_o == {a_i[HALF-1:0], a_i[WIDTH-1:HALF]}))
         else $error("half exchange wrong");
      // R10
      sign_test_chk: assert (!upd_o[FL_S] || flags_o[FL_S] == (flags_o[FL_N] ^ flags_o[FL_V]))
         else $error("S differs from N xor V");
      // R11
      keep_c_chk: assert (upd_o[FL_C] || flags_o[FL_C] == carry_i)
         else $error("unmasked carry not passed through");
      // R11
      keep_z_chk: assert (upd_o[FL_Z] || flags_o[FL_Z] == zero_i)
         else $error("unmasked zero not passed through");
      // R12
      bad_op_chk: assert (op_i <= OP_XCHG || (upd_o == '0 && !wr_en_o && result_o == '0))
         else $error("unused code had an effect");
   end

endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_flag_alu_chk (
   .op_i     (op_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .carry_i  (carry_i),
   .zero_i   (zero_i),
   .result_o (result_o),
   .wr_en_o  (wr_en_o),
   .flags_o  (flags_o),
   .upd_o    (upd_o)
);

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op;
   logic [7:0] a, b;
   logic       ci, zi;
   logic [7:0] res;
   logic       we;
   logic [5:0] fl, upd;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   flag_alu #(.WIDTH(8), .RIPPLE(1'b1)) uut (
      .op_i(op), .a_i(a), .b_i(b), .carry_i(ci), .zero_i(zi),
      .result_o(res), .wr_en_o(we), .flags_o(fl), .upd_o(upd)
   );

   function automatic string tag_of(input int code);
      case (code)
         0, 1:      return "R1";
         2:         return "R2";
         3:         return "R4";
         4, 5:      return "R3";
         6, 7, 8:   return "R5";
         9, 10:     return "R6";
         11, 12:    return "R7";
         13, 14, 15, 16, 17: return "R8";
         18:        return "R9";
         default:   return "R12";
      endcase
   endfunction

   // arithmetic reference model for an 8-bit configuration
   task automatic model(input int code, input int av, input int bv, input bit c_in, input bit z_in,
                        output logic [7:0] r, output logic w, output logic [5:0] f, output logic [5:0] m);
      int t, sa, sb, cx, st;
      bit c, z, n, v, h;
      logic [5:0] full;
      sa = (av > 127) ? av - 256 : av;
      sb = (bv > 127) ? bv - 256 : bv;
      r = 8'h00; w = 1'b1; m = 6'h00;
      c = c_in; v = 1'b0; h = 1'b0;
      case (code)
         0, 1: begin
            cx = (code == 1) ? int'(c_in) : 0;
            t = av + bv + cx; r = t[7:0]; c = (t > 255);
            h = ((av % 16) + (bv % 16) + cx) > 15;
            st = sa + sb + cx; v = (st > 127) || (st < -128); m = 6'h3F;
         end
         2, 3, 4, 5: begin
            cx = (code == 3 || code == 5) ? int'(c_in) : 0;
            t = av - bv - cx; r = t[7:0]; c = (t < 0);
            h = ((av % 16) - (bv % 16) - cx) < 0;
            st = sa - sb - cx; v = (st > 127) || (st < -128); m = 6'h3F;
            w = (code < 4);
         end
         6: begin r = av[7:0] & bv[7:0]; m = 6'b011110; end
         7: begin r = av[7:0] | bv[7:0]; m = 6'b011110; end
         8: begin r = av[7:0] ^ bv[7:0]; m = 6'b011110; end
         9: begin t = 255 - av; r = t[7:0]; c = 1'b1; m = 6'b011111; end
         10: begin
            t = 0 - av; r = t[7:0]; c = (r != 0); h = (av % 16) != 0;
            v = (r == 8'h80); m = 6'h3F;
         end
         11: begin t = av + 1; r = t[7:0]; v = (av == 127); m = 6'b011110; end
         12: begin t = av - 1; r = t[7:0]; v = (av == 128); m = 6'b011110; end
         13: begin t = av * 2; r = t[7:0]; c = (av >= 128); end
         14: begin t = av / 2; r = t[7:0]; c = (av % 2) == 1; end
         15: begin t = av / 2 + (av >= 128 ? 128 : 0); r = t[7:0]; c = (av % 2) == 1; end
         16: begin t = av * 2 + int'(c_in); r = t[7:0]; c = (av >= 128); end
         17: begin t = av / 2 + 128 * int'(c_in); r = t[7:0]; c = (av % 2) == 1; end
         18: begin t = (av % 16) * 16 + av / 16; r = t[7:0]; end
         default: begin w = 1'b0; end
      endcase
      n = r[7];
      z = (r == 8'h00);
      if (code == 3 || code == 5) z = z & z_in;
      if (code >= 13 && code <= 17) begin
         v = n ^ c; m = 6'b011111;
      end
      full = {h, n ^ v, v, n, z, c};
      for (int i = 0; i < 6; i++)
         f[i] = m[i] ? full[i] : (i == 0 ? c_in : (i == 1 ? z_in : 1'b0));
   endtask

   task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s op=%0d a=%02h b=%02h ci=%0d zi=%0d got %02h expected %02h",
                  req, what, op, a, b, ci, zi, got, exp);
      end
   endtask

   function automatic logic [7:0] pick_b(input int idx, input int av);
      case (idx)
         0: return 8'h00;
         1: return 8'h01;
         2: return 8'h0F;
         3: return 8'h7F;
         4: return 8'h80;
         5: return 8'hFF;
         6: return av[7:0];
         default: return av[7:0] ^ 8'h5A;
      endcase
   endfunction

   initial begin
      logic [7:0] er;
      logic       ew;
      logic [5:0] ef, em;
      op = '0; a = '0; b = '0; ci = 1'b0; zi = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int code = 0; code < 32; code++) begin
         for (int av = 0; av < 256; av++) begin
            for (int bi = 0; bi < 8; bi++) begin
               for (int fz = 0; fz < 4; fz++) begin
                  op = code[4:0]; a = av[7:0]; b = pick_b(bi, av);
                  ci = fz[0]; zi = fz[1];
                  #1;
                  model(code, av, int'(b), ci, zi, er, ew, ef, em);
                  check(tag_of(code), "result", res, er);
                  check((code == 4 || code == 5) ? "R3" : (code > 18 ? "R12" : "R13"),
                        "write", {7'b0, we}, {7'b0, ew});
                  check(tag_of(code), "mask", {2'b0, upd}, {2'b0, em});
                  check(tag_of(code), "flags", {2'b0, fl & em}, {2'b0, ef & em});
                  check("R10", "sign", {7'b0, fl[4]}, {7'b0, ef[4]});
                  check("R11", "kept", {2'b0, fl & ~em}, {2'b0, ef & ~em});
               end
            end
         end
      end

      // R4: two-byte compare 0x1201 against 0x1200 chains zero through the high byte
      op = 5'd4; a = 8'h01; b = 8'h00; ci = 1'b0; zi = 1'b1; #1;
      check("R4", "low compare zero", {7'b0, fl[1]}, 8'h00);
      zi = fl[1]; ci = fl[0];
      op = 5'd5; a = 8'h12; b = 8'h12; #1;
      check("R4", "chained zero stays clear", {7'b0, fl[1]}, 8'h00);
      // R4: equal words keep zero set
      op = 5'd4; a = 8'h34; b = 8'h34; ci = 1'b0; zi = 1'b0; #1;
      zi = fl[1]; ci = fl[0];
      op = 5'd5; a = 8'h12; b = 8'h12; #1;
      check("R4", "chained zero set on equal", {7'b0, fl[1]}, 8'h01);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired after 150000 cycles");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule